// File: doc/BRIEF.md
# Masked Program Counter Breakpoint Comparator

The block watches the program counter of a processor core and raises a one-cycle trigger pulse when an executed address falls on a programmed breakpoint. Four 32-bit breakpoint address registers are held. Register 0 is paired with a per-bit mask register, so one breakpoint can cover an aligned block of addresses. Registers 1 to 3 are exact addresses, and each has its own valid bit that takes it in or out of the comparison.

A debug host programs the registers through a plain write port (address, data, strobe). A control register holds a global enable and an invert bit. With invert clear, the trigger fires for PC values inside the programmed region. With invert set, it fires for PC values outside it. The core presents a PC with a valid strobe, and the trigger appears on the following clock edge.

Top module: `pc_bkpt_unit`

## Requirements
- R1: After reset every breakpoint, mask and control register holds zero and `trig_o` is low, so no PC strobe produces a trigger until the host sets the enable bit.
- R2: With the mask clear, a PC equal to breakpoint register 0 is inside the region.
- R3: A PC bit is left out of the comparison with breakpoint register 0 when the same bit of the mask register is 1.
- R4: The mask register has no effect on breakpoint registers 1 to 3, which always compare all 32 bits exactly.
- R5: Breakpoint register k (k = 1..3) takes part in the comparison only while its valid bit, control bit 1+k, is 1.
- R6: When the enable bit (control bit 0) is 0, `trig_o` stays low for every PC.
- R7: With the invert bit (control bit 1) set, the trigger fires only for a strobed PC that is outside the region, and never for one inside it.
- R8: All 32 bits take part in the comparison, including the upper byte, unless the mask excludes them.
- R9: `trig_o` is high for exactly one cycle, on the clock edge after a strobe whose PC meets the condition. It is low in every cycle that follows an edge without a strobe.
- R10: A register write takes effect on the edge where the strobe is sampled. A PC strobed in the same cycle as a write is compared against the old register values.
- R11: The write map is as follows. Addresses 0 to 3 select breakpoint registers 0 to 3, address 4 selects the mask, and address 5 selects control. Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Program counter value |
| pc_valid_i | input | 1 | PC strobe, one per executed instruction |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| trig_o | output | 1 | Registered breakpoint trigger pulse |

## Verification
The bench sets the mask so that it covers the upper byte and the low nibble. A design that applied the mask to every register would then match register 1 at a neighbouring address, and a design that ignored the mask would miss the wide-upper-byte hit. The valid bits are toggled while the PC stays on register 1 or register 3, which exposes a register that compares regardless of its valid bit. Invert is checked both on a hit that must be suppressed and on a miss that must fire. The enable bit is cleared while invert is set, so an enable decoded into the wrong position shows up. A write and a strobe share one cycle, which catches a design that forwards new register values into the compare. Writes to unmapped addresses are followed by strobes that would fire if those writes had aliased onto the mask or the control register.

// File: rtl/pc_bkpt_pkg.sv
package pc_bkpt_pkg;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_INV_BIT = 1;
  localparam int CTRL_VLD_LSB = 2;  // valid of reg k at bit 1+k
endpackage

// File: rtl/pc_bkpt_regs.sv
module pc_bkpt_regs
  import pc_bkpt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_BKPT = 4,
  parameter int REG_AW   = 3
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic [REG_AW-1:0]                  wr_addr_i,
  input  logic [ADDR_W-1:0]                  wr_data_i,
  output logic [NUM_BKPT-1:0][ADDR_W-1:0]    bkpt_o,
  output logic [ADDR_W-1:0]                  mask_o,
  output logic [NUM_BKPT-1:1]                vld_o,
  output logic                               en_o,
  output logic                               inv_o
);
  localparam int CTRL_W = NUM_BKPT + 1;
  localparam logic [REG_AW-1:0] MASK_ADDR = REG_AW'(NUM_BKPT);
  localparam logic [REG_AW-1:0] CTRL_ADDR = REG_AW'(NUM_BKPT + 1);

  logic [CTRL_W-1:0] ctrl_q;

  for (genvar i = 0; i < NUM_BKPT; i++) begin : g_bkpt
    logic [ADDR_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) val_q <= '0;
      else if (wr_en_i && wr_addr_i == REG_AW'(i)) val_q <= wr_data_i;
    end
    assign bkpt_o[i] = val_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == MASK_ADDR) mask_o <= wr_data_i;
      if (wr_addr_i == CTRL_ADDR) ctrl_q <= wr_data_i[CTRL_W-1:0];
    end
  end

  assign en_o  = ctrl_q[CTRL_EN_BIT];
  assign inv_o = ctrl_q[CTRL_INV_BIT];
  assign vld_o = ctrl_q[CTRL_W-1:CTRL_VLD_LSB];
endmodule

// File: rtl/pc_bkpt_cmp.sv
module pc_bkpt_cmp #(
  parameter int ADDR_W   = 32,
  parameter int NUM_BKPT = 4
) (
  input  logic [ADDR_W-1:0]               pc_i,
  input  logic [NUM_BKPT-1:0][ADDR_W-1:0] bkpt_i,
  input  logic [ADDR_W-1:0]               mask_i,
  input  logic [NUM_BKPT-1:1]             vld_i,
  output logic                            in_region_o
);
  logic [NUM_BKPT-1:0] hit;

  for (genvar i = 0; i < NUM_BKPT; i++) begin : g_hit
    if (i == 0) begin : g_masked
      assign hit[i] = ((pc_i ^ bkpt_i[i]) & ~mask_i) == '0;
    end else begin : g_exact
      assign hit[i] = vld_i[i] && (pc_i == bkpt_i[i]);
    end
  end

  assign in_region_o = |hit;
endmodule

// File: rtl/pc_bkpt_trig.sv
module pc_bkpt_trig (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pc_valid_i,
  input  logic en_i,
  input  logic inv_i,
  input  logic in_region_i,
  output logic trig_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_o <= 1'b0;
    else         trig_o <= pc_valid_i && en_i && (in_region_i ^ inv_i);
  end
endmodule

// File: rtl/pc_bkpt_unit.sv
module pc_bkpt_unit #(
  parameter int ADDR_W   = 32,
  parameter int NUM_BKPT = 4,
  localparam int REG_AW  = $clog2(NUM_BKPT + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              pc_valid_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic              trig_o
);
  logic [NUM_BKPT-1:0][ADDR_W-1:0] bkpt_q;
  logic [ADDR_W-1:0]               mask_q;
  logic [NUM_BKPT-1:1]             vld_q;
  logic                            en_q;
  logic                            inv_q;
  logic                            in_region;

  pc_bkpt_regs #(.ADDR_W(ADDR_W), .NUM_BKPT(NUM_BKPT), .REG_AW(REG_AW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .bkpt_o    (bkpt_q),
    .mask_o    (mask_q),
    .vld_o     (vld_q),
    .en_o      (en_q),
    .inv_o     (inv_q)
  );

  pc_bkpt_cmp #(.ADDR_W(ADDR_W), .NUM_BKPT(NUM_BKPT)) u_cmp (
    .pc_i        (pc_i),
    .bkpt_i      (bkpt_q),
    .mask_i      (mask_q),
    .vld_i       (vld_q),
    .in_region_o (in_region)
  );

  pc_bkpt_trig u_trig (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pc_valid_i  (pc_valid_i),
    .en_i        (en_q),
    .inv_i       (inv_q),
    .in_region_i (in_region),
    .trig_o      (trig_o)
  );
endmodule

// File: rtl/pc_bkpt_chk.sv
module pc_bkpt_chk #(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] pc_i,
  input logic              pc_valid_i,
  input logic              wr_en_i,
  input logic [REG_AW-1:0] wr_addr_i,
  input logic [ADDR_W-1:0] wr_data_i,
  input logic              trig_o,
  input logic [ADDR_W-1:0] bkpt0_i,
  input logic [ADDR_W-1:0] bkpt1_i,
  input logic              vld1_i,
  input logic              en_i,
  input logic              inv_i
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) reset_clear_chk: assert (!trig_o);
  end

  // R9
  strobe_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(pc_valid_i));

  // R6
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_valid_i && !en_i) |=> !trig_o);

  // R2
  exact0_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_valid_i && en_i && !inv_i && pc_i == bkpt0_i) |=> trig_o);

  // R7
  inv_suppress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_valid_i && en_i && inv_i && vld1_i && pc_i == bkpt1_i) |=> !trig_o);

  // R10
  wr_bkpt0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == '0) |=> bkpt0_i == $past(wr_data_i));
endmodule

bind pc_bkpt_unit pc_bkpt_chk #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pc_i       (pc_i),
  .pc_valid_i (pc_valid_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .trig_o     (trig_o),
  .bkpt0_i    (bkpt_q[0]),
  .bkpt1_i    (bkpt_q[1]),
  .vld1_i     (vld_q[1]),
  .en_i       (en_q),
  .inv_i      (inv_q)
);

// File: tb/sim_pc_bkpt_unit.sv
`timescale 1ns/1ps
module sim_pc_bkpt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc = '0;
  logic        pc_valid = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        trig;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit seen = 1'b0;
  bit    exp_q[$];
  string req_q[$];

  always #10 clk = ~clk;  // 50 MHz

  pc_bkpt_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .pc_valid_i(pc_valid),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .trig_o(trig)
  );

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s trig_o actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pc_step(input logic [31:0] p, input bit exp, input string req);
    @(negedge clk);
    pc_valid = 1'b1; pc = p;
    exp_q.push_back(exp); req_q.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    pc_valid = 1'b0;
  endtask

  task automatic wr_pc(input logic [2:0] a, input logic [31:0] d,
                       input logic [31:0] p, input bit exp, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    pc_valid = 1'b1; pc = p;
    exp_q.push_back(exp); req_q.push_back(req);
    @(negedge clk);
    wr_en = 1'b0; pc_valid = 1'b0;
  endtask

  // monitor
  always @(posedge clk) seen = rst_n && pc_valid;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (seen) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 unexpected strobe result actual %0b expected none", trig);
        end else begin
          bit e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          check(trig, e, r);
        end
      end else begin
        check(trig, 1'b0, "R9 idle");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(trig, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(trig, 1'b0, "R1 after reset");
    pc_step(32'h0000_0000, 1'b0, "R1");  // regs zero, enable off
    idle();

    wr(3'd0, 32'h0000_1234);
    wr(3'd5, 32'h0000_0001);             // R11 enable
    pc_step(32'h0000_1234, 1'b1, "R2");
    pc_step(32'h0000_1235, 1'b0, "R2");
    pc_step(32'hFF00_1234, 1'b0, "R8");
    idle();
    wr(3'd0, 32'hFF00_8000);
    pc_step(32'hFF00_8000, 1'b1, "R8");
    pc_step(32'h0000_8000, 1'b0, "R8");
    idle();

    wr(3'd4, 32'hFF00_000F);             // R11 mask
    wr(3'd0, 32'h0000_1230);
    pc_step(32'h0000_123A, 1'b1, "R3");
    pc_step(32'h0000_1240, 1'b0, "R3");
    pc_step(32'hAB00_123F, 1'b1, "R3");
    idle();

    wr(3'd1, 32'h0000_2000);
    pc_step(32'h0000_2000, 1'b0, "R5");  // not valid yet
    idle();
    wr(3'd5, 32'h0000_0005);
    pc_step(32'h0000_2000, 1'b1, "R5");
    pc_step(32'h0000_2001, 1'b0, "R4");
    idle();
    wr(3'd2, 32'h0000_3000);
    wr(3'd3, 32'h0000_4000);
    wr(3'd5, 32'h0000_001D);
    pc_step(32'h0000_3000, 1'b1, "R5");
    pc_step(32'h0000_4000, 1'b1, "R5");
    idle();
    wr(3'd5, 32'h0000_000D);
    pc_step(32'h0000_4000, 1'b0, "R5");
    idle();

    wr(3'd5, 32'h0000_001F);
    pc_step(32'h0000_2000, 1'b0, "R7");
    pc_step(32'h0000_7777, 1'b1, "R7");
    pc_step(32'h0000_1235, 1'b0, "R7");
    idle();
    wr(3'd5, 32'h0000_001E);
    pc_step(32'h0000_7777, 1'b0, "R6");
    idle();

    wr(3'd5, 32'h0000_0001);
    pc_step(32'h0000_1231, 1'b1, "R9");
    pc_step(32'h0000_9999, 1'b0, "R9");
    pc_step(32'h0000_1232, 1'b1, "R9");
    idle();
    repeat (2) @(negedge clk);           // matching PC held without strobe

    wr_pc(3'd0, 32'h0000_6000, 32'h0000_6000, 1'b0, "R10");
    pc_step(32'h0000_6000, 1'b1, "R10");
    idle();

    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    pc_step(32'h0000_6000, 1'b1, "R11");
    pc_step(32'h0000_1230, 1'b0, "R11");
    idle();

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 pending results actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule